// File: doc/BRIEF.md
# Affinity-Based Interrupt Routing Unit

This unit keeps one 64-bit route word for each shared peripheral interrupt and decides which processing element (PE) receives each pending interrupt. Software programs the route words through a plain memory-mapped write strobe and a combinational read path. A route word either names one PE by a four-level affinity address (directed mode) or lets any PE from a participating set take the interrupt (1-of-N mode). In 1-of-N mode the PE is picked round-robin.

Access to the route words passes through two filters. A global affinity-routing enable gates all access. A secure-only configuration blocks non-secure accesses to secure-group interrupts, unless a per-interrupt permission lets them through.

Pending state comes in as a vector. The unit presents at most one forward at a time, as an interrupt ID, a PE index and a valid flag. It holds that forward until an acknowledge arrives and delivers each pending episode once.

Top module: `spi_route_unit`

## Requirements
- R1: The route word of interrupt ID n is at byte offset 0x6000 + 8n. Aff0 is bits [7:0], Aff1 is [15:8], Aff2 is [23:16], the mode bit is bit 31 (1 = 1-of-N), and Aff3 is [39:32]. Bits [63:40] and [30:24] always read zero. A write that is accepted is returned by a read in the next cycle.
- R2: Reads of IDs 0..31, of IDs at or above 32*(LINES+1), of unaligned offsets or of offsets below 0x6000 return zero, and writes to them are dropped. A forwarded ID always lies in 32..32*(LINES+1)-1.
- R3: While `are_en_i` is low, every read returns zero, every write is dropped and no new forward starts.
- R4: While `sec_only_i` is high, a non-secure access to an interrupt with `grp_sec_i` set and `ns_allow_i` clear reads zero and its write is dropped. Secure accesses, and non-secure accesses with `ns_allow_i` set, behave normally.
- R5: In directed mode the forward names the index of the PE whose parameter affinity {Aff3,Aff2,Aff1,Aff0} equals the route's affinity.
- R6: A directed route that matches no implemented PE is never forwarded and does not block other interrupts. It is forwarded once a write makes it match.
- R7: In 1-of-N mode the PE is the first set bit of `part_mask_i`, searching upward with wrap-around from just after the PE of the previous 1-of-N forward. After reset the search starts at PE0. An empty mask forwards nothing.
- R8: Among eligible pending interrupts, the lowest ID is forwarded first.
- R9: A forward appears on the clock edge after its interrupt becomes eligible. ID and PE stay stable until the cycle in which `fwd_ack_i` is sampled high, and `fwd_vld_o` drops after that edge. Route writes made meanwhile do not change it.
- R10: After an acknowledge, the same interrupt is not forwarded again until its pending input has been low for at least one clock edge.
- R11: After reset no forward is valid and all route words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| are_en_i | input | 1 | Affinity routing enable |
| sec_only_i | input | 1 | Secure-only access configuration active |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 64 | Write data |
| reg_secure_i | input | 1 | Access is secure |
| reg_rdata_o | output | 64 | Read data for reg_addr_i |
| grp_sec_i | input | 32*LINES | Per-SPI flag: Group 0 or Secure Group 1 |
| ns_allow_i | input | 32*LINES | Per-SPI non-secure access permission |
| pend_i | input | 32*LINES | Per-SPI pending state, bit k is ID 32+k |
| part_mask_i | input | NUM_PE | Participating PEs for 1-of-N |
| fwd_vld_o | output | 1 | Forward valid |
| fwd_id_o | output | 10 | Forwarded interrupt ID |
| fwd_pe_o | output | clog2(NUM_PE) | Target PE index |
| fwd_ack_i | input | 1 | Forward accepted |

## Verification
The assertions check, on every cycle, that a forward holds still until it is acknowledged and clears right after, and that forwarded IDs stay inside the shared range. They also check that reads return zero for reserved bits, for the low reserved window and while routing is disabled, and that nothing launches while routing is disabled. Which PE is chosen, the round-robin order, the lowest-ID ordering and the skipping of unmatched directed routes can only be shown by the bench's scenarios. The same holds for once-only delivery across an acknowledge and the secure access filter. The bench compares these against its own model of the route words.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam int ADDR_W    = 16;
  localparam int AFF_W     = 32;
  localparam int ID_W      = 10;
  localparam int FIRST_SPI = 32;
  localparam logic [ADDR_W-1:0] BASE_OFF = 16'h6000;

  typedef struct packed {
    logic             one_of_n;
    logic [AFF_W-1:0] aff;  // {aff3, aff2, aff1, aff0}
  } route_t;

  function automatic logic [63:0] pack_route(route_t r);
    return {24'h0, r.aff[31:24], r.one_of_n, 7'h0, r.aff[23:0]};
  endfunction
endpackage

// File: rtl/spi_route_regs.sv
module spi_route_regs
  import spi_route_pkg::*;
#(
  parameter int NUM_SPI = 32,
  localparam int SPI_W  = $clog2(NUM_SPI)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              are_en_i,
  input  logic              sec_only_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  input  logic              secure_i,
  input  logic [NUM_SPI-1:0] grp_sec_i,
  input  logic [NUM_SPI-1:0] ns_allow_i,
  output logic [63:0]       rdata_o,
  output route_t            routes_o [NUM_SPI]
);
  localparam int IDX_W = ADDR_W - 3;

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx, rel;
  logic [SPI_W-1:0]  sel;
  logic              in_win, allowed, acc;
  logic              unused_bits;

  assign off    = addr_i - BASE_OFF;
  assign idx    = off[ADDR_W-1:3];
  assign rel    = idx - IDX_W'(FIRST_SPI);
  assign sel    = rel[SPI_W-1:0];
  assign in_win = (addr_i >= BASE_OFF) && (off[2:0] == 3'b0) &&
                  (idx >= IDX_W'(FIRST_SPI)) && (idx < IDX_W'(FIRST_SPI + NUM_SPI));
  assign allowed = !sec_only_i || secure_i || !grp_sec_i[sel] || ns_allow_i[sel];
  assign acc     = are_en_i && in_win && allowed;
  assign unused_bits = ^{wdata_i[63:40], wdata_i[30:24], rel[IDX_W-1:SPI_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_SPI; k++) routes_o[k] <= '0;
    end else if (wr_i && acc) begin
      routes_o[sel] <= '{one_of_n: wdata_i[31], aff: {wdata_i[39:32], wdata_i[23:0]}};
    end
  end

  assign rdata_o = acc ? pack_route(routes_o[sel]) : 64'h0;
endmodule

// File: rtl/spi_route_pick.sv
module spi_route_pick
  import spi_route_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int NUM_PE  = 4,
  parameter logic [NUM_PE*AFF_W-1:0] PE_AFF = '0,
  localparam int SPI_W = $clog2(NUM_SPI),
  localparam int PE_W  = $clog2(NUM_PE)
) (
  input  route_t             routes_i [NUM_SPI],
  input  logic [NUM_SPI-1:0] pend_i,
  input  logic [NUM_SPI-1:0] served_i,
  input  logic [NUM_PE-1:0]  part_mask_i,
  input  logic [PE_W-1:0]    rr_ptr_i,
  output logic               cand_vld_o,
  output logic [SPI_W-1:0]   cand_sel_o,
  output logic [PE_W-1:0]    cand_pe_o,
  output logic               cand_rr_o
);
  logic [NUM_SPI-1:0] dir_ok, elig;
  logic [PE_W-1:0]    dir_pe [NUM_SPI];
  logic               rr_ok;
  logic [PE_W-1:0]    rr_pe;

  // directed affinity match per interrupt
  for (genvar k = 0; k < NUM_SPI; k++) begin : g_match
    logic            ok_k;
    logic [PE_W-1:0] pe_k;
    always_comb begin
      ok_k = 1'b0;
      pe_k = '0;
      for (int p = NUM_PE - 1; p >= 0; p--) begin
        if (routes_i[k].aff == PE_AFF[p*AFF_W +: AFF_W]) begin
          ok_k = 1'b1;
          pe_k = PE_W'(p);
        end
      end
    end
    assign dir_ok[k] = ok_k;
    assign dir_pe[k] = pe_k;
    assign elig[k]   = pend_i[k] && !served_i[k] &&
                       (routes_i[k].one_of_n ? rr_ok : ok_k);
  end

  // round-robin: first participant after the last one served
  always_comb begin
    rr_ok = 1'b0;
    rr_pe = '0;
    for (int i = NUM_PE; i >= 1; i--) begin
      int c;
      c = (int'(rr_ptr_i) + i) % NUM_PE;
      if (part_mask_i[PE_W'(c)]) begin
        rr_ok = 1'b1;
        rr_pe = PE_W'(c);
      end
    end
  end

  always_comb begin
    cand_vld_o = |elig;
    cand_sel_o = '0;
    for (int k = NUM_SPI - 1; k >= 0; k--) begin
      if (elig[k]) cand_sel_o = SPI_W'(k);
    end
    cand_rr_o = routes_i[cand_sel_o].one_of_n;
    cand_pe_o = cand_rr_o ? rr_pe : dir_pe[cand_sel_o];
  end

  logic unused_ok;
  assign unused_ok = ^dir_ok;
endmodule

// File: rtl/spi_route_unit.sv
module spi_route_unit
  import spi_route_pkg::*;
#(
  parameter int LINES  = 1,
  parameter int NUM_PE = 4,
  parameter logic [NUM_PE*AFF_W-1:0] PE_AFF =
    {32'h01000101, 32'h00000100, 32'h00000001, 32'h00000000},
  localparam int NUM_SPI = 32 * LINES,
  localparam int SPI_W   = $clog2(NUM_SPI),
  localparam int PE_W    = $clog2(NUM_PE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               are_en_i,
  input  logic               sec_only_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [63:0]        reg_wdata_i,
  input  logic               reg_secure_i,
  output logic [63:0]        reg_rdata_o,
  input  logic [NUM_SPI-1:0] grp_sec_i,
  input  logic [NUM_SPI-1:0] ns_allow_i,
  input  logic [NUM_SPI-1:0] pend_i,
  input  logic [NUM_PE-1:0]  part_mask_i,
  output logic               fwd_vld_o,
  output logic [ID_W-1:0]    fwd_id_o,
  output logic [PE_W-1:0]    fwd_pe_o,
  input  logic               fwd_ack_i
);
  route_t             routes [NUM_SPI];
  logic [NUM_SPI-1:0] served_q, ack_set;
  logic [PE_W-1:0]    rr_ptr_q, cand_pe, fwd_pe_q;
  logic [SPI_W-1:0]   cand_sel, fwd_sel_q;
  logic               cand_vld, cand_rr, fwd_vld_q, launch;

  spi_route_regs #(.NUM_SPI(NUM_SPI)) u_regs (
    .clk_i, .rst_ni, .are_en_i, .sec_only_i,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .secure_i(reg_secure_i), .grp_sec_i, .ns_allow_i,
    .rdata_o(reg_rdata_o), .routes_o(routes)
  );

  spi_route_pick #(.NUM_SPI(NUM_SPI), .NUM_PE(NUM_PE), .PE_AFF(PE_AFF)) u_pick (
    .routes_i(routes), .pend_i, .served_i(served_q), .part_mask_i,
    .rr_ptr_i(rr_ptr_q), .cand_vld_o(cand_vld), .cand_sel_o(cand_sel),
    .cand_pe_o(cand_pe), .cand_rr_o(cand_rr)
  );

  assign launch = !fwd_vld_q && are_en_i && cand_vld;

  always_comb begin
    ack_set = '0;
    if (fwd_vld_q && fwd_ack_i) ack_set[fwd_sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_vld_q <= 1'b0;
      fwd_sel_q <= '0;
      fwd_pe_q  <= '0;
      served_q  <= '0;
      rr_ptr_q  <= PE_W'(NUM_PE - 1);
    end else begin
      // an episode stays served until its pending input drops
      served_q <= (served_q & pend_i) | ack_set;
      if (launch) begin
        fwd_vld_q <= 1'b1;
        fwd_sel_q <= cand_sel;
        fwd_pe_q  <= cand_pe;
        if (cand_rr) rr_ptr_q <= cand_pe;
      end else if (fwd_vld_q && fwd_ack_i) begin
        fwd_vld_q <= 1'b0;
      end
    end
  end

  assign fwd_vld_o = fwd_vld_q;
  assign fwd_id_o  = ID_W'(fwd_sel_q) + ID_W'(FIRST_SPI);
  assign fwd_pe_o  = fwd_pe_q;
endmodule

// File: rtl/spi_route_chk.sv
module spi_route_chk #(
  parameter int NUM_SPI = 32,
  parameter int PE_W    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            are_en,
  input logic [15:0]     addr,
  input logic [63:0]     rdata,
  input logic            fwd_vld,
  input logic [9:0]      fwd_id,
  input logic [PE_W-1:0] fwd_pe,
  input logic            ack
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld && !ack |=> fwd_vld && $stable(fwd_id) && $stable(fwd_pe));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld && ack |=> !fwd_vld);

  p_id_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_vld |-> (fwd_id >= 10'd32) && (fwd_id < 10'(32 + NUM_SPI)));

  p_low_window_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr < 16'h6100 |-> rdata == 64'h0);

  p_off_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !are_en |-> rdata == 64'h0);

  p_off_no_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_vld && !are_en |=> !fwd_vld);

  p_rsvd_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[63:40] == 24'h0 && rdata[30:24] == 7'h0);
endmodule

bind spi_route_unit spi_route_chk #(.NUM_SPI(NUM_SPI), .PE_W(PE_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .are_en(are_en_i), .addr(reg_addr_i),
  .rdata(reg_rdata_o), .fwd_vld(fwd_vld_o), .fwd_id(fwd_id_o),
  .fwd_pe(fwd_pe_o), .ack(fwd_ack_i)
);

// File: tb/spi_route_unit_test.sv
module spi_route_unit_test;
  localparam int CLK_P = 10;
  localparam int NSPI  = 32;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        are_en = 1'b1, sec_only = 1'b0, wr = 1'b0, secure = 1'b0, ack = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic [NSPI-1:0] grp = '0, nsal = '0, pend = '0;
  logic [3:0]  pmask = '0;
  logic        fvld;
  logic [9:0]  fid;
  logic [1:0]  fpe;
  int total = 0, bad = 0;
  logic [32:0] mdl [NSPI];

  always #(CLK_P/2) clk = ~clk;

  spi_route_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .are_en_i(are_en), .sec_only_i(sec_only),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_secure_i(secure),
    .reg_rdata_o(rdata), .grp_sec_i(grp), .ns_allow_i(nsal), .pend_i(pend),
    .part_mask_i(pmask), .fwd_vld_o(fvld), .fwd_id_o(fid), .fwd_pe_o(fpe),
    .fwd_ack_i(ack)
  );

  function automatic logic [15:0] addr_of(int n);
    return 16'(24576 + 8 * n);
  endfunction

  // -1: outside window, else SPI slot
  function automatic int slot_of(logic [15:0] a);
    int n;
    if (a < 16'h6000 || a[2:0] != 3'b0) return -1;
    n = (int'(a) - 24576) / 8;
    if (n < 32 || n >= 32 + NSPI) return -1;
    return n - 32;
  endfunction

  function automatic bit blocked(int k, bit s);
    return sec_only && !s && grp[k] && !nsal[k];
  endfunction

  function automatic logic [63:0] exp_rd(logic [15:0] a, bit s);
    int k;
    k = slot_of(a);
    if (!are_en || k < 0) return 64'h0;
    if (blocked(k, s)) return 64'h0;
    return {24'h0, mdl[k][31:24], mdl[k][32], 7'h0, mdl[k][23:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_fwd(string tag, bit v, int id, int pe);
    chk({tag, " vld"}, 64'(fvld), 64'(v));
    if (v && fvld) begin
      chk({tag, " id"}, 64'(fid), 64'(id));
      chk({tag, " pe"}, 64'(fpe), 64'(pe));
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic do_write(logic [15:0] a, logic [63:0] d, bit s);
    int k;
    k = slot_of(a);
    wr = 1'b1; addr = a; wdata = d; secure = s;
    if (are_en && k >= 0 && !blocked(k, s))
      mdl[k] = {d[31], d[39:32], d[23:0]};
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_ack(int drop_slot);
    ack = 1'b1;
    if (drop_slot >= 0) pend[drop_slot] = 1'b0;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NSPI; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk("R11 fwd idle", 64'(fvld), 64'h0);
    addr = addr_of(40); secure = 1'b1;
    #1 chk("R11 route zero", rdata, 64'h0);
    @(negedge clk);

    // R1..R4 random register traffic
    for (int it = 0; it < 250; it++) begin
      logic [15:0] a;
      logic [63:0] d;
      bit ws, rs;
      string tag;
      int k;
      are_en   = ($urandom_range(0, 7) != 0);
      sec_only = $urandom_range(0, 1);
      grp      = $urandom;
      nsal     = $urandom;
      a = addr_of($urandom_range(0, 70));
      if ($urandom_range(0, 9) == 0) a = a + 16'($urandom_range(1, 7));
      if ($urandom_range(0, 19) == 0) a = 16'($urandom_range(0, 24575));
      d  = {$urandom, $urandom};
      ws = $urandom_range(0, 1);
      rs = $urandom_range(0, 1);
      k  = slot_of(a);
      if (!are_en) tag = "R3";
      else if (k < 0) tag = "R2";
      else if (blocked(k, ws) || blocked(k, rs)) tag = "R4";
      else tag = "R1";
      do_write(a, d, ws);
      addr = a; secure = rs;
      #1 chk({tag, " readback"}, rdata, exp_rd(a, rs));
      if (k >= 0) begin
        are_en = 1'b1; sec_only = 1'b0;
        #1 chk({tag, " stored word"}, rdata, exp_rd(a, rs));
      end
      @(negedge clk);
    end

    are_en = 1'b1; sec_only = 1'b0;

    // R4 directed: secure-only filter
    sec_only = 1'b1; grp[5] = 1'b1; nsal[5] = 1'b0;
    do_write(addr_of(37), 64'h1, 1'b1);
    do_write(addr_of(37), 64'h100, 1'b0);
    addr = addr_of(37); secure = 1'b1;
    #1 chk("R4 ns write dropped", rdata, 64'h1);
    secure = 1'b0;
    #1 chk("R4 ns read zero", rdata, 64'h0);
    nsal[5] = 1'b1;
    #1 chk("R4 ns permitted", rdata, 64'h1);
    sec_only = 1'b0;
    @(negedge clk);

    // R5 / R10: directed target, once per episode
    do_write(addr_of(40), 64'h100, 1'b1);
    pend[8] = 1'b1;
    @(negedge clk); #1 chk_fwd("R5 directed PE2", 1, 40, 2);
    do_ack(-1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 chk_fwd("R10 no duplicate", 0, 0, 0);
    end
    pend[8] = 1'b0;
    @(negedge clk);
    pend[8] = 1'b1;
    @(negedge clk); #1 chk_fwd("R10 new episode", 1, 40, 2);
    do_ack(8);

    // R9: rewrite while in flight
    do_write(addr_of(41), 64'h1, 1'b1);
    pend[9] = 1'b1;
    @(negedge clk); #1 chk_fwd("R9 launch", 1, 41, 1);
    do_write(addr_of(41), 64'h0000_0001_0000_0101, 1'b1);
    @(negedge clk); #1 chk_fwd("R9 held route", 1, 41, 1);
    do_ack(9);

    // R6: unmatched affinity is skipped and stays pending
    do_write(addr_of(42), 64'h0000_0005_0000_0000, 1'b1);
    do_write(addr_of(45), 64'h0, 1'b1);
    pend[10] = 1'b1; pend[13] = 1'b1;
    @(negedge clk); #1 chk_fwd("R6 skip unmatched", 1, 45, 0);
    do_ack(13);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1 chk_fwd("R6 not forwarded", 0, 0, 0);
    end
    do_write(addr_of(42), 64'h0000_0001_0000_0101, 1'b1);
    @(negedge clk); #1 chk_fwd("R6 after rematch", 1, 42, 3);
    do_ack(10);

    // R8: lowest ID first
    do_write(addr_of(44), 64'h0, 1'b1);
    do_write(addr_of(50), 64'h0, 1'b1);
    pend[12] = 1'b1; pend[18] = 1'b1;
    @(negedge clk); #1 chk_fwd("R8 lowest first", 1, 44, 0);
    do_ack(12);
    @(negedge clk); #1 chk_fwd("R8 next", 1, 50, 0);
    do_ack(18);

    // R7: round-robin over participants
    pmask = 4'b1011;
    do_write(addr_of(60), 64'h8000_0000, 1'b1);
    pend[28] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      int exp_pe;
      exp_pe = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 3 : 0;
      @(negedge clk); #1 chk_fwd("R7 rotation", 1, 60, exp_pe);
      do_ack(28);
      @(negedge clk);
      pend[28] = 1'b1;
    end
    pmask = 4'b0000;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1 chk_fwd("R7 empty mask", 0, 0, 0);
    end
    pmask = 4'b0100;
    @(negedge clk); #1 chk_fwd("R7 single participant", 1, 60, 2);
    do_ack(28);

    // R3: disabled routing launches nothing
    @(negedge clk);
    are_en = 1'b0; pend[13] = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); #1 chk_fwd("R3 no forward", 0, 0, 0);
    end
    are_en = 1'b1;
    @(negedge clk); #1 chk_fwd("R3 re-enabled", 1, 45, 0);
    do_ack(13);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule